// File: doc/BRIEF.md
# Pipelined Bit-Serial Longest-Length Selector

This block picks one winner from a set of candidate entries. Each entry has a 5-bit length. The winner is the candidate whose length is largest. A lookup engine produces the candidate vector, and each set bit marks an entry that still needs a tie-break on stored length. The selector works bit-serially, starting from the most significant length bit, and handles one bit per pipeline stage. At each stage it discards the candidates that can no longer be the largest. When a single candidate is left with a 1 in the examined bit, that candidate is settled early, and its result travels unchanged through the remaining stages.

Five length bits are resolved in four stages. The last stage takes the second-lowest bit and the lowest bit together. Once the upper four bits have been narrowed, any candidates still left differ at most in bit 0, so the candidate with a 1 there wins. If the lengths are exactly equal, the lowest index wins.

Both data edges use valid/ready. The input is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is delivered on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes and `in_ready` is low. When there is no back-pressure, a new vector is accepted every cycle.

Top module: `bitserial_max_sel`

## Requirements
- R1: An entry whose candidate bit is 0 never wins, whatever its length. Entry e's length is `in_lens[e*5 +: 5]`, unsigned.
- R2: When at least one candidate exists, `out_found` is 1 and the winner is a candidate with the largest length among the candidates.
- R3: A candidate that is the only one with a 1 at the most significant length bit wins, regardless of its lower bits.
- R4: At each examined bit, only the candidates with a 1 stay in contention. If no candidate has a 1 at that bit, all current candidates stay.
- R5: Candidates equal in the upper four length bits are settled by bit 0, and the one with bit 0 = 1 wins.
- R6: Among candidates with identical lengths, the lowest-indexed entry wins.
- R7: An all-zero candidate vector gives `out_found` = 0, `out_win` = 0 and `out_idx` = 0.
- R8: With `out_ready` held high, the result appears with `out_valid` = 1 right after the fourth rising edge, counting the accepting edge as the first. Vectors accepted on consecutive edges produce results on consecutive cycles, in order.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold. After reset, `out_valid` = 0 and `in_ready` = 1.
- R10: `out_win` is one-hot or zero. When `out_found` = 1, the bit of `out_win` at position `out_idx` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Candidate vector and lengths are valid |
| in_ready | output | 1 | Pipeline can accept a vector |
| in_cand | input | N | Candidate flags, bit e for entry e |
| in_lens | input | N*LEN_W | Per-entry lengths, entry e at `[e*LEN_W +: LEN_W]` |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_win | output | N | One-hot winner vector |
| out_idx | output | $clog2(N) | Winner index |
| out_found | output | 1 | At least one candidate was present |

## Verification
The assertions check the output-side rules on every cycle:
- the winner vector is one-hot or zero;
- the index points at the set bit;
- an empty result reports index zero;
- a stalled output holds steady while input readiness stays low.

Which entry actually wins depends on the lengths that came in four edges earlier. The bench's scenarios alone show this, each covering one case:
- early MSB resolution;
- narrowing when no candidate has a 1;
- the bit-0 shortcut;
- equal-length ties;
- masked non-candidates;
- back-to-back streaming.

// File: rtl/msel_pkg.sv
package msel_pkg;

  // Bit offset of stage s's length segment inside the concatenated length bus.
  // Stage s carries (w - s) bits for each of n entries.
  function automatic int unsigned seg_off(int unsigned n, int unsigned w, int unsigned s);
    int unsigned t;
    t = 0;
    for (int unsigned k = 0; k < s; k++) t += n * (w - k);
    return t;
  endfunction

endpackage

// File: rtl/msel_stage.sv
// One narrowing stage: examines length bit BIT and drops the bits already used.
module msel_stage #(
  parameter int unsigned N   = 16,
  parameter int unsigned BIT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v_i,
  input  logic [N-1:0]         cand_i,
  input  logic                 done_i,
  input  logic [N-1:0]         win_i,
  input  logic [N*(BIT+1)-1:0] lens_i,
  output logic                 v_o,
  output logic [N-1:0]         cand_o,
  output logic                 done_o,
  output logic [N-1:0]         win_o,
  output logic [N*BIT-1:0]     lens_o
);
  localparam int unsigned IW  = BIT + 1;
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0]     col, hit, keep;
  logic [N*BIT-1:0] rest;
  logic             any_hit, sole;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      col[e]             = lens_i[e*IW + BIT];
      rest[e*BIT +: BIT] = lens_i[e*IW +: BIT];
    end
    hit     = cand_i & col;
    any_hit = |hit;
    sole    = any_hit && ((hit & (hit - ONE)) == '0);
    keep    = any_hit ? hit : cand_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      cand_o <= '0;
      done_o <= 1'b0;
      win_o  <= '0;
      lens_o <= '0;
    end else if (en) begin
      v_o    <= v_i;
      cand_o <= done_i ? '0 : keep;
      done_o <= done_i | sole;
      win_o  <= done_i ? win_i : (sole ? hit : '0);
      lens_o <= rest;
    end
  end
endmodule

// File: rtl/msel_final.sv
// Last stage: examines bit 1, then settles on bit 0, then lowest index.
module msel_final #(
  parameter int unsigned N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           v_i,
  input  logic [N-1:0]   cand_i,
  input  logic           done_i,
  input  logic [N-1:0]   win_i,
  input  logic [N*2-1:0] lens_i,
  output logic           v_o,
  output logic [N-1:0]   win_o
);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] b1, b0, hit1, k1, hit0, k0, pick;

  always_comb begin
    for (int e = 0; e < N; e++) begin
      b1[e] = lens_i[e*2 + 1];
      b0[e] = lens_i[e*2];
    end
    hit1 = cand_i & b1;
    k1   = (hit1 != '0) ? hit1 : cand_i;
    hit0 = k1 & b0;
    k0   = (hit0 != '0) ? hit0 : k1;
    pick = k0 & (~k0 + ONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      win_o <= '0;
    end else if (en) begin
      v_o   <= v_i;
      win_o <= done_i ? win_i : pick;
    end
  end
endmodule

// File: rtl/msel_idx_enc.sv
module msel_idx_enc #(
  parameter int unsigned N  = 16,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  win_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (win_i[i]) idx_o = IW'(i);
    end
    any_o = |win_i;
  end
endmodule

// File: rtl/bitserial_max_sel.sv
module bitserial_max_sel #(
  parameter int unsigned N     = 16,
  parameter int unsigned LEN_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N-1:0]           in_cand,
  input  logic [N*LEN_W-1:0]     in_lens,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [N-1:0]           out_win,
  output logic [$clog2(N)-1:0]   out_idx,
  output logic                   out_found
);
  localparam int unsigned NS     = LEN_W - 1;
  localparam int unsigned IDX_W  = $clog2(N);
  localparam int unsigned LBUS_W = msel_pkg::seg_off(N, LEN_W, NS);

  logic                   en;
  logic [NS-1:0]          vb, db;
  logic [NS-1:0][N-1:0]   cb, wb;
  logic [LBUS_W-1:0]      lb;

  assign en       = out_ready || !out_valid;
  assign in_ready = en;

  assign vb[0]              = in_valid;
  assign cb[0]              = in_cand;
  assign db[0]              = 1'b0;
  assign wb[0]              = '0;
  assign lb[0 +: N*LEN_W]   = in_lens;

  for (genvar s = 0; s < NS - 1; s++) begin : g_stage
    msel_stage #(.N(N), .BIT(LEN_W - 1 - s)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .v_i    (vb[s]),
      .cand_i (cb[s]),
      .done_i (db[s]),
      .win_i  (wb[s]),
      .lens_i (lb[msel_pkg::seg_off(N, LEN_W, s) +: N*(LEN_W-s)]),
      .v_o    (vb[s+1]),
      .cand_o (cb[s+1]),
      .done_o (db[s+1]),
      .win_o  (wb[s+1]),
      .lens_o (lb[msel_pkg::seg_off(N, LEN_W, s+1) +: N*(LEN_W-s-1)])
    );
  end

  msel_final #(.N(N)) u_final (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .v_i    (vb[NS-1]),
    .cand_i (cb[NS-1]),
    .done_i (db[NS-1]),
    .win_i  (wb[NS-1]),
    .lens_i (lb[msel_pkg::seg_off(N, LEN_W, NS-1) +: N*2]),
    .v_o    (out_valid),
    .win_o  (out_win)
  );

  msel_idx_enc #(.N(N), .IW(IDX_W)) u_enc (
    .win_i (out_win),
    .idx_o (out_idx),
    .any_o (out_found)
  );
endmodule

// File: rtl/msel_checker.sv
module msel_checker #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [N-1:0]     out_win,
  input logic [IDX_W-1:0] out_idx,
  input logic             out_found
);
  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_win)); // R10
  AST_IDX_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_found) |-> out_win[out_idx]); // R10
  AST_EMPTY_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_found) |-> (out_idx == '0 && out_win == '0)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_win))); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
endmodule

bind bitserial_max_sel msel_checker #(.N(N), .IDX_W($clog2(N))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_win   (out_win),
  .out_idx   (out_idx),
  .out_found (out_found)
);

// File: tb/bitserial_max_sel_tb_top.sv
module bitserial_max_sel_tb_top;
  localparam int N = 16;
  localparam int W = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [N-1:0]  in_cand = '0;
  logic [N*W-1:0] in_lens = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [N-1:0]  out_win;
  logic [3:0]    out_idx;
  logic          out_found;

  logic [N*W-1:0] lv;
  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitserial_max_sel #(.N(N), .LEN_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cand(in_cand), .in_lens(in_lens), .out_valid(out_valid),
    .out_ready(out_ready), .out_win(out_win), .out_idx(out_idx),
    .out_found(out_found)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(int e, int v);
    lv[e*W +: W] = W'(v);
  endtask

  function automatic void model(input logic [N-1:0] c, input logic [N*W-1:0] l,
                                output int idx, output bit fnd);
    int best = -1;
    idx = 0; fnd = 0;
    for (int e = 0; e < N; e++) begin
      if (c[e] && int'(l[e*W +: W]) > best) begin
        best = int'(l[e*W +: W]); idx = e; fnd = 1;
      end
    end
  endfunction

  task automatic check_res(string req, int eidx, bit ef);
    int ew = ef ? (1 << eidx) : 0;
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(out_found == ef, req, "out_found", int'(out_found), int'(ef));
    chk(int'(out_idx) == (ef ? eidx : 0), req, "out_idx", int'(out_idx), ef ? eidx : 0);
    chk(int'(out_win) == ew, req, "out_win", int'(out_win), ew);
  endtask

  // Single vector, no back-pressure; result after the 4th edge (R8).
  task automatic run_case(string req, logic [N-1:0] c);
    int ei; bit ef;
    @(negedge clk);
    in_valid = 1'b1; in_cand = c; in_lens = lv; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model(c, lv, ei, ef);
    check_res(req, ei, ef);
  endtask

  task automatic t_general;   // R2
    lv = '0; put(2, 7); put(5, 20); put(9, 13); put(12, 3);
    run_case("R2", 16'h0224);
  endtask

  task automatic t_masked;    // R1
    lv = '0; put(0, 31); put(3, 10); put(4, 11); put(15, 30);
    run_case("R1", 16'h0018);
  endtask

  task automatic t_early;     // R3
    lv = '0; put(1, 16); put(6, 15); put(8, 14);
    run_case("R3", 16'h0142);
  endtask

  task automatic t_nonenarrow; // R4
    lv = '0; put(2, 5); put(7, 9); put(11, 8); put(13, 1);
    run_case("R4", 16'h2884);
  endtask

  task automatic t_lastbit;   // R5
    lv = '0; put(3, 22); put(12, 23);
    run_case("R5", 16'h1008);
    lv = '0; put(3, 23); put(12, 22);
    run_case("R5", 16'h1008);
  endtask

  task automatic t_tie;       // R6
    lv = '0; put(4, 18); put(10, 18); put(14, 18);
    run_case("R6", 16'h4410);
    lv = '0;
    run_case("R6", 16'h8001);
  endtask

  task automatic t_empty;     // R7
    lv = '1;
    run_case("R7", 16'h0000);
  endtask

  task automatic t_stream;    // R8
    logic [N-1:0]   cs [4];
    logic [N*W-1:0] ls [4];
    int ei; bit ef;
    cs[0] = 16'h0003; cs[1] = 16'h00F0; cs[2] = 16'h0000; cs[3] = 16'hFFFF;
    for (int k = 0; k < 4; k++) begin
      lv = '0;
      for (int e = 0; e < N; e++) put(e, (e * 7 + k * 5) % 32);
      ls[k] = lv;
    end
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_cand = cs[k]; in_lens = ls[k];
      @(posedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      model(cs[k], ls[k], ei, ef);
      check_res("R8", ei, ef);
      if (k < 3) @(posedge clk);
    end
  endtask

  task automatic t_stall;     // R9
    logic [N-1:0] wa;
    int ei; bit ef;
    lv = '0; put(6, 25); put(9, 12);
    @(negedge clk);
    in_valid = 1'b1; in_cand = 16'h0240; in_lens = lv; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_res("R9", 6, 1'b1);
    wa = out_win;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b0, "R9", "in_ready stalled", int'(in_ready), 0);
      chk(out_valid && out_win == wa, "R9", "held out_win", int'(out_win), int'(wa));
    end
    lv = '0; put(1, 4); put(2, 9);
    in_valid = 1'b1; in_cand = 16'h0006; in_lens = lv; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R9", "bubble after release", int'(out_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    model(16'h0006, lv, ei, ef);
    check_res("R9", ei, ef);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "reset in_ready", int'(in_ready), 1);
    t_general();
    t_masked();
    t_early();
    t_nonenarrow();
    t_lastbit();
    t_tie();
    t_empty();
    t_stream();
    t_stall();
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule